// File: doc/BRIEF.md
# Timer Edge Capture with Glitch Filter

This block timestamps an edge on an external input. The raw pin is brought into the clock domain by a chain of flip-flops. It can then be passed through a majority-free persistence filter, which accepts a new level only once that level has been sampled on several consecutive clocks. An edge detector watches the resulting level for the edge direction that software selects. When that edge is found, the value of a free-running counter, which is supplied from outside, is latched into a capture register and a sticky capture flag is raised.

The flag stays set until a one-cycle clear strobe arrives, and it drives a registered interrupt request when interrupts are enabled. When the surrounding timer uses the capture register as its period limit, a mode input cuts the pin off from the capture path. The register then keeps its value. The counter, prescaler and waveform logic live elsewhere.

Top module: `icu_capture_top`

## Requirements
- R1: After synchronous reset the capture value, flag and interrupt request are all 0, and the level the pin holds through reset and the start-up cycles causes no capture.
- R2: With the filter off, a qualifying pin change that is set up before rising clock edge k is captured at edge k+2. The capture value is the count input presented before edge k+2, and the flag rises at the same edge.
- R3: With the filter on, the same pin change is captured at edge k+6, four clocks later than on the unfiltered path, with the count presented before that edge.
- R4: With the filter on, a pin pulse that lasts fewer than four clock samples produces no capture and leaves the capture value unchanged.
- R5: The edge select input set to 1 captures on a rising level and set to 0 captures on a falling level; the opposite edge is ignored.
- R6: While the period-limit mode input is 1, pin edges produce no capture and the capture value holds. Edges seen in that mode are not captured later, once the mode returns to 0.
- R7: The capture flag stays 1 until a clear strobe is sampled, and it reads 0 one clock after that strobe when no capture occurs in the same cycle.
- R8: When a capture and a clear strobe occur in the same cycle, the flag ends up 1 and the new value is loaded.
- R9: The interrupt request is a register equal to the flag AND the interrupt enable as sampled at the previous clock edge.
- R10: Switching the filter on or off while the pin is steady produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W | Free-running counter value to latch |
| filt_en_i | input | 1 | 1 enables the persistence filter |
| rise_sel_i | input | 1 | Edge select: 1 rising, 0 falling |
| top_sel_i | input | 1 | 1 when the capture register is the counter's period limit; capture is off |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| cap_val_o | output | CNT_W | Captured counter value |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench measures the capture latency to the exact clock on both the filtered and the unfiltered path. A design with one synchronizer stage too many or too few, or a filter that is off by one sample, would latch a count one higher or lower than expected. A three-sample glitch is applied with the filter on: a filter that flips on the third sample would capture it. The bench also drives the edge the design should ignore, and an edge detector that ignores polarity would raise the flag on it.

A clear strobe is placed in the same cycle as a capture, so a design that lets the clear win would drop the flag. The pin is toggled while the period-limit mode is active and the mode is then left. A design that keeps sampling in that mode, or that reports a stale edge afterwards, would change the register or raise the flag. The pin is held high through reset, and the filter is switched on and off with a steady pin. A design that starts its level history from a fixed 0 would report a phantom edge in either of these cases.

// File: rtl/icu_pkg.sv
package icu_pkg;
  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[i] <= 1'b0;
        else     stg_q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[i] <= 1'b0;
        else     stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/icu_filter.sv
module icu_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic warm,
  input  logic en,
  input  logic din,
  output logic dout
);
  if (LEN < 2) begin : g_bypass
    logic unused_ok;
    assign unused_ok = clk ^ rst ^ warm ^ en;
    assign dout = din;
  end else begin : g_filt
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);
    logic [CW-1:0] run_q;
    logic          lvl_q;
    logic          en_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        run_q <= '0;
        lvl_q <= 1'b0;
        en_q  <= 1'b0;
      end else begin
        en_q <= en;
        if (warm || !en) begin
          // track the input so enabling starts from the current level
          lvl_q <= din;
          run_q <= '0;
        end else if (en != en_q) begin
          run_q <= '0;
        end else if (din == lvl_q) begin
          run_q <= '0;
        end else if (run_q == LAST) begin
          lvl_q <= din;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end

    assign dout = lvl_q;
  end
endmodule

// File: rtl/icu_edge.sv
module icu_edge
  import icu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      warm,
  input  logic      lvl,
  input  edge_pol_e pol,
  output logic      hit
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  // a change toward the selected polarity is a qualifying edge
  assign hit = !warm && (lvl != prev_q) && (lvl == logic'(pol));
endmodule

// File: rtl/icu_capreg.sv
module icu_capreg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             block,
  input  logic [CNT_W-1:0] count,
  input  logic             clr,
  input  logic             ie,
  output logic             fire,
  output logic [CNT_W-1:0] cap_q,
  output logic             flag_q,
  output logic             irq_q
);
  logic flag_nx;

  assign fire = hit && !block;

  always_comb begin
    flag_nx = flag_q;
    if (fire)     flag_nx = 1'b1;
    else if (clr) flag_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (fire) cap_q <= count;
      flag_q <= flag_nx;
      irq_q  <= flag_nx && ie;
    end
  end
endmodule

// File: rtl/icu_capture_top.sv
module icu_capture_top
  import icu_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             filt_en_i,
  input  logic             rise_sel_i,
  input  logic             top_sel_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             irq_o
);
  // cycles after reset during which history registers only follow the pin
  localparam int WARM = SYNC_STAGES + 2;
  localparam int WW   = $clog2(WARM + 1);

  logic [WW-1:0] warm_q;
  logic          warm;
  logic          sync_lvl;
  logic          filt_lvl;
  logic          lvl;
  logic          hit;
  logic          fire;

  always_ff @(posedge clk) begin
    if (rst)         warm_q <= WW'(WARM);
    else if (warm)   warm_q <= warm_q - 1'b1;
  end
  assign warm = (warm_q != '0);

  icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (cap_pin_i),
    .dout(sync_lvl)
  );

  icu_filter #(.LEN(FILT_LEN)) u_filt (
    .clk (clk),
    .rst (rst),
    .warm(warm),
    .en  (filt_en_i),
    .din (sync_lvl),
    .dout(filt_lvl)
  );

  assign lvl = filt_en_i ? filt_lvl : sync_lvl;

  icu_edge u_edge (
    .clk (clk),
    .rst (rst),
    .warm(warm),
    .lvl (lvl),
    .pol (edge_pol_e'(rise_sel_i)),
    .hit (hit)
  );

  icu_capreg #(.CNT_W(CNT_W)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .hit   (hit),
    .block (top_sel_i),
    .count (count_i),
    .clr   (flag_clr_i),
    .ie    (irq_en_i),
    .fire  (fire),
    .cap_q (cap_val_o),
    .flag_q(cap_flag_o),
    .irq_q (irq_o)
  );
endmodule

// File: rtl/icu_capture_chk.sv
module icu_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count_i,
  input logic             top_sel_i,
  input logic             irq_en_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_flag_o,
  input logic             irq_o,
  input logic             fire
);
  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (cap_flag_o && $past(irq_en_i)));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_flag_o && !flag_clr_i) |=> cap_flag_o);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i && !fire) |=> !cap_flag_o);

  // R2
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cap_flag_o && cap_val_o == $past(count_i)));

  // R6
  top_hold_chk: assert property (@(posedge clk) disable iff (rst)
    top_sel_i |=> $stable(cap_val_o));
endmodule

bind icu_capture_top icu_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .count_i   (count_i),
  .top_sel_i (top_sel_i),
  .irq_en_i  (irq_en_i),
  .flag_clr_i(flag_clr_i),
  .cap_val_o (cap_val_o),
  .cap_flag_o(cap_flag_o),
  .irq_o     (irq_o),
  .fire      (fire)
);

// File: tb/sim_icu_capture_top.sv
module sim_icu_capture_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cap_pin_i = 1'b1;
  logic [CNT_W-1:0] count_i = 16'hFFF0;
  logic             filt_en_i = 1'b0;
  logic             rise_sel_i = 1'b1;
  logic             top_sel_i = 1'b0;
  logic             irq_en_i = 1'b0;
  logic             flag_clr_i = 1'b0;
  logic [CNT_W-1:0] cap_val_o;
  logic             cap_flag_o;
  logic             irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icu_capture_top #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .cap_pin_i(cap_pin_i), .count_i(count_i),
    .filt_en_i(filt_en_i), .rise_sel_i(rise_sel_i), .top_sel_i(top_sel_i),
    .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i), .cap_val_o(cap_val_o),
    .cap_flag_o(cap_flag_o), .irq_o(irq_o)
  );

  // each tick lands on a falling edge and advances the counter input
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      count_i = count_i + 1'b1;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    tick(1);
    flag_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(8);
    check("R1 cap after reset", 32'(cap_val_o), 32'h0);
    check("R1 flag after reset", 32'(cap_flag_o), 32'h0);
    check("R1 irq after reset", 32'(irq_o), 32'h0);
  endtask

  task automatic t_unfiltered();
    logic [CNT_W-1:0] v;
    rise_sel_i = 1'b1;
    cap_pin_i = 1'b0;
    tick(6);
    check("R5 falling ignored when rise selected", 32'(cap_flag_o), 32'h0);
    cap_pin_i = 1'b1;
    v = count_i;
    tick(2);
    check("R2 no capture before edge k+2", 32'(cap_flag_o), 32'h0);
    tick(1);
    check("R2 flag at edge k+2", 32'(cap_flag_o), 32'h1);
    check("R2 capture value", 32'(cap_val_o), 32'(v + 16'd2));
  endtask

  task automatic t_sticky_clear();
    tick(5);
    check("R7 flag sticky", 32'(cap_flag_o), 32'h1);
    clear_flag();
    check("R7 flag cleared", 32'(cap_flag_o), 32'h0);
  endtask

  task automatic t_falling();
    logic [CNT_W-1:0] v;
    rise_sel_i = 1'b0;
    cap_pin_i = 1'b0;
    v = count_i;
    tick(3);
    check("R5 falling captured", 32'(cap_flag_o), 32'h1);
    check("R5 falling value", 32'(cap_val_o), 32'(v + 16'd2));
    clear_flag();
  endtask

  task automatic t_filter_toggle();
    logic [CNT_W-1:0] keep;
    keep = cap_val_o;
    filt_en_i = 1'b1;
    tick(6);
    check("R10 enable filter no capture", 32'(cap_flag_o), 32'h0);
    check("R10 value unchanged", 32'(cap_val_o), 32'(keep));
  endtask

  task automatic t_glitch();
    logic [CNT_W-1:0] keep;
    keep = cap_val_o;
    rise_sel_i = 1'b1;
    cap_pin_i = 1'b1;
    tick(3);
    cap_pin_i = 1'b0;
    tick(10);
    check("R4 short pulse rejected", 32'(cap_flag_o), 32'h0);
    check("R4 value kept", 32'(cap_val_o), 32'(keep));
  endtask

  task automatic t_filtered();
    logic [CNT_W-1:0] v;
    cap_pin_i = 1'b1;
    v = count_i;
    tick(6);
    check("R3 no capture before edge k+6", 32'(cap_flag_o), 32'h0);
    tick(1);
    check("R3 flag at edge k+6", 32'(cap_flag_o), 32'h1);
    check("R3 filtered value", 32'(cap_val_o), 32'(v + 16'd6));
    clear_flag();
  endtask

  task automatic t_collision();
    logic [CNT_W-1:0] v;
    filt_en_i = 1'b0;
    tick(4);
    check("R10 disable filter no capture", 32'(cap_flag_o), 32'h0);
    rise_sel_i = 1'b0;
    cap_pin_i = 1'b0;
    v = count_i;
    tick(2);
    flag_clr_i = 1'b1;
    tick(1);
    flag_clr_i = 1'b0;
    check("R8 capture beats clear", 32'(cap_flag_o), 32'h1);
    check("R8 value loaded", 32'(cap_val_o), 32'(v + 16'd2));
  endtask

  task automatic t_irq();
    irq_en_i = 1'b0;
    tick(1);
    check("R9 irq masked", 32'(irq_o), 32'h0);
    irq_en_i = 1'b1;
    tick(1);
    check("R9 irq raised", 32'(irq_o), 32'h1);
    clear_flag();
    check("R9 irq drops with flag", 32'(irq_o), 32'h0);
    irq_en_i = 1'b0;
  endtask

  task automatic t_top_mode();
    logic [CNT_W-1:0] keep;
    keep = cap_val_o;
    top_sel_i = 1'b1;
    rise_sel_i = 1'b1;
    cap_pin_i = 1'b1;
    tick(4);
    cap_pin_i = 1'b0;
    tick(4);
    cap_pin_i = 1'b1;
    tick(5);
    check("R6 no flag in top mode", 32'(cap_flag_o), 32'h0);
    check("R6 value held in top mode", 32'(cap_val_o), 32'(keep));
    top_sel_i = 1'b0;
    tick(6);
    check("R6 no stale capture after top mode", 32'(cap_flag_o), 32'h0);
    check("R6 value still held", 32'(cap_val_o), 32'(keep));
  endtask

  initial begin
    t_reset();
    t_unfiltered();
    t_sticky_clear();
    t_falling();
    t_filter_toggle();
    t_glitch();
    t_filtered();
    t_collision();
    t_irq();
    t_top_mode();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule